// File: doc/BRIEF.md
# Idle-State Entry and Package Sleep Controller

This block follows the power state of every hardware thread in a small multi-core package. It decides from those states when each core's clock may stop and when the whole package may ask for deep sleep. Each thread is in one of three states: active (C0), shallow idle (C1) or deep idle (C2). A thread moves to C1 when its monitor/wait event fires. It moves to C2 when it issues an I/O read whose address lands on a fixed offset inside a decode window, and that window starts at a base held in a register that software can write. A wake event on a thread returns it to C0.

For each core the block drives a clock enable, a wake-latency figure and a cycle counter that stops while the core is gated. For each thread it drives a power hint. For the package it drives one sleep request. A thread marked offline counts as holding C1, so it can stop its core's clock but always blocks package sleep. Other packages report through one input that is high when every one of their threads is in C2. The package sleep request is combinational on the wake inputs, so a wake withdraws it in the same cycle.

Top module: `idle_pkg_ctrl`

## Requirements
- R1: During and right after reset every thread is in C0 (`thr_state` code 0), every `core_clk_en` bit is 1, every `core_cycles` count is 0, `pkg_sleep_req` is 0 and the decode base is `BASE_RST` (default 0).
- R2: A thread in C0 with its `mwait_req` bit high, no wake and no deep-entry read in that cycle shows C1 (code 1) on `thr_state` after the next clock edge. Thread t occupies bits [2t+1:2t] of `thr_state`.
- R3: A thread in C0 that is named by `io_rd_tid` in a cycle with `io_rd_valid` high and `io_rd_addr` equal to base + 0x814, with the address at or above the base and less than `RANGE_SZ` (4096) bytes past it, shows C2 (code 2) after the next edge. In the same cycle this deep entry wins over a monitor/wait request.
- R4: An I/O read to any other offset inside the window, or to an address below the base or beyond the window, leaves the thread state unchanged.
- R5: A cycle with `base_wr_en` high loads `base_wr_data` into the decode base. Reads in that same cycle still decode against the old base, and the new base applies from the next cycle.
- R6: A thread whose `wake` bit is high returns to C0 after the next edge, whatever its state and whatever other request it makes in that cycle.
- R7: A thread in C1 or C2 ignores monitor/wait and deep-entry requests and holds its state until it is woken.
- R8: `core_clk_en[c]` is 0 exactly when every thread of core c (threads c*TPC to c*TPC+TPC-1) is in C1 or C2, where an offline thread counts as C1.
- R9: `core_cycles` for core c grows by one, wrapping at 2^CNT_W, after each edge at which `core_clk_en[c]` was 1, and otherwise holds its value.
- R10: `pkg_sleep_req` is 1 exactly when every thread of this package holds C2 and is not offline, `peer_all_deep` is 1, and no `wake` bit is high in the current cycle.
- R11: `core_wake_lat[c]` is 0 when any thread of core c is active, 400 when every thread of core c is in C2 and online, and 1 otherwise (offline counts as C1).
- R12: `thr_pwr_hint` for a thread is all ones while the thread is in C0 and zero while it is in C1 or C2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr_en | input | 1 | Load the decode base |
| base_wr_data | input | ADDR_W | New decode base |
| mwait_req | input | NTHR | Per-thread monitor/wait event (enter C1) |
| io_rd_valid | input | 1 | I/O read present |
| io_rd_tid | input | TID_W | Thread issuing the I/O read |
| io_rd_addr | input | ADDR_W | I/O read address |
| wake | input | NTHR | Per-thread wake or interrupt event |
| offline | input | NTHR | Per-thread offline marker |
| peer_all_deep | input | 1 | All threads of the other packages are in C2 |
| thr_state | output | 2*NTHR | Per-thread state code: 0 C0, 1 C1, 2 C2 |
| thr_pwr_hint | output | PWR_W*NTHR | Per-thread advertised power value |
| core_clk_en | output | NUM_CORES | Per-core clock enable (0 = gated) |
| core_wake_lat | output | LAT_W*NUM_CORES | Per-core exit latency in microseconds |
| core_cycles | output | CNT_W*NUM_CORES | Per-core cycle counter |
| pkg_sleep_req | output | 1 | Package deep-sleep request |

## Verification
Some rules are checked on every cycle: a wake always lands the thread in C0, an idle thread holds its state until woken, a gated core's counter holds, any wake blocks the sleep request, a sleep request implies every core is gated, and the power hint follows the state. The address decode can only be shown by the bench's scenarios. These cover the exact offset against its neighbours, addresses below and beyond the window, and the one-cycle lag of a base write. The scenarios also cover offline threads, which stop a core's clock but block package sleep, and the latency figures for mixed and uniform cores. A behavioural reference model, compared every cycle, covers the interleavings between these scenarios.

// File: rtl/idle_pkg.sv
package idle_pkg;

    typedef enum logic [1:0] {
        CST_ACTIVE  = 2'd0,
        CST_SHALLOW = 2'd1,
        CST_DEEP    = 2'd2
    } cstate_e;

    // Depth used for aggregation: an offline thread counts as shallow idle.
    function automatic cstate_e effective_state(input cstate_e st, input logic off);
        return off ? CST_SHALLOW : st;
    endfunction

endpackage

// File: rtl/idle_thread_fsm.sv
module idle_thread_fsm
    import idle_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_i,
    input  logic       mwait_i,
    input  logic       deep_hit_i,
    output logic [1:0] state_o
);

    typedef struct packed {
        cstate_e st;
    } thr_regs_t;

    localparam thr_regs_t THR_RESET = '{st: CST_ACTIVE};

    thr_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (wake_i) begin
            nxt_d.st = CST_ACTIVE;
        end else if (cur_q.st == CST_ACTIVE) begin
            if (deep_hit_i) begin
                nxt_d.st = CST_DEEP;
            end else if (mwait_i) begin
                nxt_d.st = CST_SHALLOW;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= THR_RESET;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state_o = cur_q.st;

endmodule

// File: rtl/idle_core_domain.sv
module idle_core_domain
    import idle_pkg::*;
#(
    parameter int unsigned TPC       = 2,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned LAT_W     = 10,
    parameter int unsigned LAT_C1_US = 1,
    parameter int unsigned LAT_C2_US = 400
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*TPC-1:0]     thr_st_i,
    input  logic [TPC-1:0]       offline_i,
    output logic                 clk_en_o,
    output logic                 all_deep_o,
    output logic [LAT_W-1:0]     lat_o,
    output logic [CNT_W-1:0]     cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } core_regs_t;

    localparam core_regs_t CORE_RESET = '{cnt: '0};

    core_regs_t cur_q, nxt_d;
    logic [TPC-1:0] thr_active;
    logic [TPC-1:0] thr_deep;

    for (genvar k = 0; k < TPC; k++) begin : g_thr
        cstate_e st_k;
        cstate_e eff_k;
        assign st_k          = cstate_e'(thr_st_i[2*k +: 2]);
        assign eff_k         = effective_state(st_k, offline_i[k]);
        assign thr_active[k] = (eff_k == CST_ACTIVE);
        assign thr_deep[k]   = (eff_k == CST_DEEP);
    end

    logic any_active;
    logic every_deep;

    always_comb begin
        any_active = |thr_active;
        every_deep = &thr_deep;
        nxt_d      = cur_q;
        if (any_active) begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= CORE_RESET;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign clk_en_o   = any_active;
    assign all_deep_o = every_deep;
    assign lat_o      = any_active ? '0 :
                        (every_deep ? LAT_W'(LAT_C2_US) : LAT_W'(LAT_C1_US));
    assign cnt_o      = cur_q.cnt;

endmodule

// File: rtl/idle_pkg_ctrl.sv
module idle_pkg_ctrl
    import idle_pkg::*;
#(
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned TPC       = 2,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned RANGE_SZ  = 4096,
    parameter int unsigned DEEP_OFF  = 'h814,
    parameter int unsigned BASE_RST  = 0,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned LAT_W     = 10,
    parameter int unsigned LAT_C1_US = 1,
    parameter int unsigned LAT_C2_US = 400,
    parameter int unsigned PWR_W     = 8,
    localparam int unsigned NTHR     = NUM_CORES * TPC,
    localparam int unsigned TID_W    = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        base_wr_en,
    input  logic [ADDR_W-1:0]           base_wr_data,
    input  logic [NTHR-1:0]             mwait_req,
    input  logic                        io_rd_valid,
    input  logic [TID_W-1:0]            io_rd_tid,
    input  logic [ADDR_W-1:0]           io_rd_addr,
    input  logic [NTHR-1:0]             wake,
    input  logic [NTHR-1:0]             offline,
    input  logic                        peer_all_deep,
    output logic [2*NTHR-1:0]           thr_state,
    output logic [PWR_W*NTHR-1:0]       thr_pwr_hint,
    output logic [NUM_CORES-1:0]        core_clk_en,
    output logic [LAT_W*NUM_CORES-1:0]  core_wake_lat,
    output logic [CNT_W*NUM_CORES-1:0]  core_cycles,
    output logic                        pkg_sleep_req
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
    } top_regs_t;

    localparam top_regs_t TOP_RESET = '{base: ADDR_W'(BASE_RST)};

    top_regs_t cur_q, nxt_d;

    logic [ADDR_W:0]     off_w;
    logic                in_window;
    logic                at_deep_off;
    logic [NTHR-1:0]     deep_hit;
    logic [NUM_CORES-1:0] core_all_deep;

    // Base register and window decode (decode uses the stored base).
    always_comb begin
        nxt_d = cur_q;
        if (base_wr_en) begin
            nxt_d.base = base_wr_data;
        end
        off_w       = {1'b0, io_rd_addr} - {1'b0, cur_q.base};
        in_window   = !off_w[ADDR_W] && (32'(off_w) < RANGE_SZ);
        at_deep_off = (off_w[ADDR_W-1:0] == ADDR_W'(DEEP_OFF));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= TOP_RESET;
        end else begin
            cur_q <= nxt_d;
        end
    end

    for (genvar t = 0; t < NTHR; t++) begin : g_thread
        assign deep_hit[t] = io_rd_valid && (io_rd_tid == TID_W'(t)) &&
                             in_window && at_deep_off;

        idle_thread_fsm i_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .wake_i     (wake[t]),
            .mwait_i    (mwait_req[t]),
            .deep_hit_i (deep_hit[t]),
            .state_o    (thr_state[2*t +: 2])
        );

        assign thr_pwr_hint[PWR_W*t +: PWR_W] =
            (cstate_e'(thr_state[2*t +: 2]) == CST_ACTIVE) ? {PWR_W{1'b1}} : '0;
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        idle_core_domain #(
            .TPC       (TPC),
            .CNT_W     (CNT_W),
            .LAT_W     (LAT_W),
            .LAT_C1_US (LAT_C1_US),
            .LAT_C2_US (LAT_C2_US)
        ) i_core (
            .clk        (clk),
            .rst_n      (rst_n),
            .thr_st_i   (thr_state[2*TPC*c +: 2*TPC]),
            .offline_i  (offline[TPC*c +: TPC]),
            .clk_en_o   (core_clk_en[c]),
            .all_deep_o (core_all_deep[c]),
            .lat_o      (core_wake_lat[LAT_W*c +: LAT_W]),
            .cnt_o      (core_cycles[CNT_W*c +: CNT_W])
        );
    end

    // Wake withdraws the request in the same cycle.
    assign pkg_sleep_req = (&core_all_deep) && peer_all_deep && !(|wake);

endmodule

// File: rtl/idle_pkg_ctrl_chk.sv
module idle_pkg_ctrl_chk #(
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned TPC       = 2,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned PWR_W     = 8,
    localparam int unsigned NTHR     = NUM_CORES * TPC
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NTHR-1:0]             mwait_req,
    input logic                        io_rd_valid,
    input logic [NTHR-1:0]             wake,
    input logic [2*NTHR-1:0]           thr_state,
    input logic [PWR_W*NTHR-1:0]       thr_pwr_hint,
    input logic [NUM_CORES-1:0]        core_clk_en,
    input logic [CNT_W*NUM_CORES-1:0]  core_cycles,
    input logic                        pkg_sleep_req
);

    for (genvar t = 0; t < NTHR; t++) begin : g_thr_chk
        // R6
        wake_to_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wake[t] |=> (thr_state[2*t +: 2] == 2'd0));

        // R2
        mwait_to_shallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_state[2*t +: 2] == 2'd0 && mwait_req[t] && !wake[t] && !io_rd_valid)
            |=> (thr_state[2*t +: 2] == 2'd1));

        // R7
        idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_state[2*t +: 2] != 2'd0 && !wake[t]) |=> $stable(thr_state[2*t +: 2]));

        // R12
        pwr_hint_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_state[2*t +: 2] == 2'd0) ? (&thr_pwr_hint[PWR_W*t +: PWR_W])
                                          : (thr_pwr_hint[PWR_W*t +: PWR_W] == '0));
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_chk
        // R9
        gated_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !core_clk_en[c] |=> $stable(core_cycles[CNT_W*c +: CNT_W]));
    end

    // R10
    wake_blocks_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wake) |-> !pkg_sleep_req);

    // R8
    sleep_implies_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkg_sleep_req |-> (core_clk_en == '0));

endmodule

bind idle_pkg_ctrl idle_pkg_ctrl_chk #(
    .NUM_CORES (NUM_CORES),
    .TPC       (TPC),
    .CNT_W     (CNT_W),
    .PWR_W     (PWR_W)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mwait_req     (mwait_req),
    .io_rd_valid   (io_rd_valid),
    .wake          (wake),
    .thr_state     (thr_state),
    .thr_pwr_hint  (thr_pwr_hint),
    .core_clk_en   (core_clk_en),
    .core_cycles   (core_cycles),
    .pkg_sleep_req (pkg_sleep_req)
);

// File: tb/test_idle_pkg_ctrl.sv
`timescale 1ns/100ps
module test_idle_pkg_ctrl;

    localparam int NC   = 4;
    localparam int TPC  = 2;
    localparam int NT   = NC * TPC;
    localparam int AW   = 16;
    localparam int CW   = 16;
    localparam int LW   = 10;
    localparam int PW   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic base_wr_en = 1'b0;
    logic [AW-1:0] base_wr_data = '0;
    logic [NT-1:0] mwait_req = '0;
    logic io_rd_valid = 1'b0;
    logic [2:0] io_rd_tid = '0;
    logic [AW-1:0] io_rd_addr = '0;
    logic [NT-1:0] wake = '0;
    logic [NT-1:0] offline = '0;
    logic peer_all_deep = 1'b0;
    logic [2*NT-1:0] thr_state;
    logic [PW*NT-1:0] thr_pwr_hint;
    logic [NC-1:0] core_clk_en;
    logic [LW*NC-1:0] core_wake_lat;
    logic [CW*NC-1:0] core_cycles;
    logic pkg_sleep_req;

    always #2.5 clk = ~clk;

    idle_pkg_ctrl i_idle_pkg_ctrl (
        .clk(clk), .rst_n(rst_n), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .mwait_req(mwait_req), .io_rd_valid(io_rd_valid), .io_rd_tid(io_rd_tid),
        .io_rd_addr(io_rd_addr), .wake(wake), .offline(offline),
        .peer_all_deep(peer_all_deep), .thr_state(thr_state), .thr_pwr_hint(thr_pwr_hint),
        .core_clk_en(core_clk_en), .core_wake_lat(core_wake_lat),
        .core_cycles(core_cycles), .pkg_sleep_req(pkg_sleep_req)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_st[NT];
    int m_base;
    int m_cnt[NC];

    function automatic int eff_st(input int t);
        return offline[t] ? 1 : m_st[t];
    endfunction

    function automatic bit m_core_en(input int c);
        for (int k = 0; k < TPC; k++) if (eff_st(c*TPC+k) == 0) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit m_core_deep(input int c);
        for (int k = 0; k < TPC; k++) if (eff_st(c*TPC+k) != 2) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit m_hit(input int t);
        int a;
        a = int'(io_rd_addr);
        return io_rd_valid && int'(io_rd_tid) == t && a >= m_base &&
               (a - m_base) < 4096 && (a - m_base) == 'h814;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) m_st[t] = 0;
            for (int c = 0; c < NC; c++) m_cnt[c] = 0;
            m_base = 0;
        end else begin
            for (int c = 0; c < NC; c++)
                if (m_core_en(c)) m_cnt[c] = (m_cnt[c] + 1) % 65536;
            for (int t = 0; t < NT; t++) begin
                if (wake[t]) m_st[t] = 0;
                else if (m_st[t] == 0) begin
                    if (m_hit(t)) m_st[t] = 2;
                    else if (mwait_req[t]) m_st[t] = 1;
                end
            end
            if (base_wr_en) m_base = int'(base_wr_data);
        end
    end

    always @(negedge clk) begin
        #1;
        if (!done) begin
            bit all_deep;
            all_deep = 1'b1;
            for (int t = 0; t < NT; t++) begin
                check("R2/R3/R6", $sformatf("model thr%0d state", t),
                      int'(thr_state[2*t +: 2]), m_st[t]);
                check("R12", $sformatf("model thr%0d pwr", t),
                      int'(thr_pwr_hint[PW*t +: PW]), (m_st[t] == 0) ? 255 : 0);
            end
            for (int c = 0; c < NC; c++) begin
                if (!m_core_deep(c)) all_deep = 1'b0;
                check("R8", $sformatf("model core%0d clk_en", c),
                      int'(core_clk_en[c]), int'(m_core_en(c)));
                check("R9", $sformatf("model core%0d cycles", c),
                      int'(core_cycles[CW*c +: CW]), m_cnt[c]);
                check("R11", $sformatf("model core%0d lat", c),
                      int'(core_wake_lat[LW*c +: LW]),
                      m_core_en(c) ? 0 : (m_core_deep(c) ? 400 : 1));
            end
            check("R10", "model pkg_sleep_req", int'(pkg_sleep_req),
                  int'(all_deep && peer_all_deep && wake == '0));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic io_read(input int tid, input int addr);
        @(negedge clk);
        io_rd_valid = 1'b1; io_rd_tid = 3'(tid); io_rd_addr = AW'(addr);
        @(negedge clk);
        io_rd_valid = 1'b0;
        #1.5;
    endtask

    task automatic pulse_mwait(input logic [NT-1:0] m);
        @(negedge clk); mwait_req = m;
        @(negedge clk); mwait_req = '0;
        #1.5;
    endtask

    function automatic int st_of(input int t);
        return int'(thr_state[2*t +: 2]);
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int saved;
        repeat (3) @(negedge clk);
        #1.5;
        // R1: reset values
        check("R1", "state", int'(thr_state), 0);
        check("R1", "clk_en", int'(core_clk_en), 15);
        check("R1", "cycles", int'(core_cycles != '0), 0);
        check("R1", "sleep", int'(pkg_sleep_req), 0);
        @(negedge clk); rst_n = 1'b1;

        // R2: monitor/wait on thread 0
        pulse_mwait(8'h01);
        check("R2", "thr0", st_of(0), 1);
        check("R8", "core0 still clocked", int'(core_clk_en[0]), 1);

        // R3: deep read on thread 1 at base 0 + 0x814
        io_read(1, 'h0814);
        check("R3", "thr1", st_of(1), 2);
        check("R8", "core0 gated", int'(core_clk_en[0]), 0);
        check("R11", "core0 mixed lat", int'(core_wake_lat[LW-1:0]), 1);

        // R9: gated counter holds
        saved = int'(core_cycles[CW-1:0]);
        repeat (3) @(negedge clk);
        #1.5;
        check("R9", "core0 held", int'(core_cycles[CW-1:0]), saved);

        // R7: idle thread ignores requests
        io_read(0, 'h0814);
        check("R7", "thr0 stays C1", st_of(0), 1);
        pulse_mwait(8'h02);
        check("R7", "thr1 stays C2", st_of(1), 2);

        // R4: wrong offset and out of window ignored
        io_read(2, 'h0810);
        check("R4", "thr2 off 0x810", st_of(2), 0);
        io_read(2, 'h1814);
        check("R4", "thr2 beyond window", st_of(2), 0);

        // R5: base write with same-cycle read uses old base
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = 16'h1000;
        io_rd_valid = 1'b1; io_rd_tid = 3'd2; io_rd_addr = 16'h1814;
        @(negedge clk);
        base_wr_en = 1'b0; io_rd_valid = 1'b0;
        #1.5;
        check("R5", "old base applies", st_of(2), 0);
        io_read(2, 'h1814);
        check("R5", "new base applies", st_of(2), 2);
        io_read(3, 'h0814);
        check("R4", "thr3 below base", st_of(3), 0);

        // R6: wake has priority over same-cycle requests
        @(negedge clk);
        wake = 8'h0B; mwait_req = 8'h08;
        #1.5;
        check("R10", "no sleep during wake", int'(pkg_sleep_req), 0);
        @(negedge clk);
        wake = '0; mwait_req = '0;
        #1.5;
        check("R6", "thr0", st_of(0), 0);
        check("R6", "thr1", st_of(1), 0);
        check("R6", "thr3 wake beats mwait", st_of(3), 0);

        // R10: whole package deep
        for (int t = 0; t < NT; t++) if (t != 2) io_read(t, 'h1814);
        check("R10", "peer low", int'(pkg_sleep_req), 0);
        @(negedge clk); peer_all_deep = 1'b1;
        #1.5;
        check("R10", "all deep", int'(pkg_sleep_req), 1);
        check("R11", "core3 deep lat", int'(core_wake_lat[LW*3 +: LW]), 400);
        check("R12", "thr0 pwr idle", int'(thr_pwr_hint[PW-1:0]), 0);

        // offline thread blocks sleep, counts as shallow
        @(negedge clk); offline = 8'h20;
        #1.5;
        check("R10", "offline blocks", int'(pkg_sleep_req), 0);
        check("R11", "core2 offline lat", int'(core_wake_lat[LW*2 +: LW]), 1);
        check("R8", "core2 gated offline", int'(core_clk_en[2]), 0);
        @(negedge clk); offline = '0;
        #1.5;
        check("R10", "restored", int'(pkg_sleep_req), 1);

        // wake withdraws sleep in the same cycle
        @(negedge clk); wake = 8'h80;
        #1.5;
        check("R10", "wake same cycle", int'(pkg_sleep_req), 0);
        @(negedge clk); wake = '0;
        #1.5;
        check("R6", "thr7 woken", st_of(7), 0);
        check("R12", "thr7 pwr active", int'(thr_pwr_hint[PW*7 +: PW]), 255);

        // offline active thread lets its core gate
        @(negedge clk); offline = 8'h80;
        #1.5;
        check("R8", "core3 gated with offline C0", int'(core_clk_en[3]), 0);
        @(negedge clk); offline = '0;
        repeat (4) @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule